// File: doc/BRIEF.md
# Touch Controller Setup Register Engine

This block is the setup command path of a touch screen controller's serial slave port. While chip select is low, it receives a command byte and then either a 4-bit write nibble or a 4-bit read-back. It holds the controller's configuration in four nibble-wide registers:

- panel and framing options;
- scan sequence selection;
- sampling interval;
- sleep control, together with a read-only sequencer status field.

The configuration fields drive the conversion framer and the scan sequencer directly. The status field arrives from the sequencer on an input.

One address is special. It carries the internal-clock sequence commands. With the write bit, it produces a single-cycle arm pulse for the sequencer. With the read bit, it produces a single-cycle pulse that hands the frame over to the result read-out path, and this block does not drive the data line in that frame.

The serial pins are synchronised into the system clock domain. Edges of the serial clock are detected there. Input data is taken on rising serial clock edges, and output data changes after falling edges. Instead of a tri-state pin, the block exposes an output-enable signal.

Top module: `touch_setup_regs`

## Requirements
- R1: After reset, all configuration outputs are 0 (4-wire panel, single-shot mode, 6 conversions, no data delay, sequence 000, interval 000, sleep 00). Also after reset, dout_oe_o and dout_o are 0 and neither pulse output is asserted.
- R2: A byte is a setup command only when bits 7..4 are 1010. Bits 3..1 are then the address, and bit 0 selects read (1) or write (0). Any other byte is ignored for the rest of the frame: no register changes, no pulse, and DOUT is never enabled.
- R3: A setup write takes its data nibble on serial clocks 9..12, MSB first. Address 000 maps panel_5w_o, cont_mode_o, conv_cnt_o and data_dly_o to bits 3, 2, 1 and 0. Address 001 maps seq_mode_o to bits 3..1. Address 010 maps interval_o to bits 3..1. Address 011 maps sleep_o to bits 3..2.
- R4: A write changes nothing unless the 12th rising serial clock edge arrives before chip select rises.
- R5: In a setup read, clock 9 is a turnaround clock. dout_oe_o rises after the falling edge of clock 9 and falls after the falling edge of clock 13. The nibble is presented MSB first so that the master samples bits 3..0 on rising edges 10..13. dout_oe_o is low at all other times.
- R6: Read data uses the R3 layout, with bit 0 of addresses 001 and 010 reading 0. Address 011 returns {sleep, seq_status_i}, where the status is sampled at the falling edge of clock 9. Status codes are 00 idle, 01 sampling wait, 10 sequence busy and 11 data available.
- R7: Write data bits 1..0 at address 011 have no effect, because the status field is read-only.
- R8: A write of sleep code 11, which is reserved, leaves sleep_o unchanged. The other codes are 00 normal, 01 and 10 sleep variants.
- R9: Writes to addresses 100..110 change no register. Reads from them drive 0000 with dout_oe_o following R5.
- R10: A setup command to address 111 produces exactly one system-clock pulse after the 8th rising edge: seq_arm_o when bit 0 is 0, or result_rd_o when bit 0 is 1. It changes no register and does not enable DOUT.
- R11: Chip select high clears dout_oe_o and the bit count, so every frame starts fresh at bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, idle low |
| din_i | input | 1 | Serial data in |
| seq_status_i | input | 2 | Sequencer status for the read-only field |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Output enable for the serial data pad |
| panel_5w_o | output | 1 | Panel type, 1 selects 5-wire |
| cont_mode_o | output | 1 | Continuous conversion mode |
| conv_cnt_o | output | 1 | Conversion count select, 0 selects 6 and 1 selects 10 |
| data_dly_o | output | 1 | Output data delay select |
| seq_mode_o | output | 3 | Scan sequence mode |
| interval_o | output | 3 | Sampling interval code |
| sleep_o | output | 2 | Sleep mode code |
| seq_arm_o | output | 1 | One-cycle pulse that arms the internal-clock sequence |
| result_rd_o | output | 1 | One-cycle pulse that starts the sequence result read-out |

## Verification
The assertions assume that serial clock half periods span several system clocks, that the serial clock is low whenever chip select changes, and that seq_status_i stays steady during a read frame. The bench holds each serial clock phase for 8 system clocks. It changes data only while the serial clock is low, opens and closes chip select with the clock low, and fixes the status before each frame. Random frames mix setup and foreign command bytes, all eight addresses and both directions. They also vary the frame length from 8 to 13 clocks, so that truncated writes and cut-off reads appear alongside complete ones.

// File: rtl/touch_setup_pkg.sv
package touch_setup_pkg;
  localparam int CMD_BITS  = 8;
  localparam int DATA_BITS = 4;
  localparam int WR_LAST   = CMD_BITS + DATA_BITS;      // 12
  localparam int RD_FIRST  = CMD_BITS + 1;              // turnaround clock
  localparam int RD_LAST   = RD_FIRST + DATA_BITS;      // 13
  localparam int CNT_W     = $clog2(RD_LAST + 3);

  localparam logic [3:0] SETUP_PREFIX = 4'b1010;
  localparam logic [2:0] A_FUNC  = 3'd0;
  localparam logic [2:0] A_SEQ   = 3'd1;
  localparam logic [2:0] A_INTV  = 3'd2;
  localparam logic [2:0] A_PWR   = 3'd3;
  localparam logic [2:0] A_AUTO  = 3'd7;
  localparam logic [1:0] SLEEP_RSVD = 2'b11;

  typedef struct packed {
    logic       panel_5w;
    logic       cont;
    logic       cnt10;
    logic       ddly;
    logic [2:0] seq_mode;
    logic [2:0] interval;
    logic [1:0] sleep;
  } setup_regs_t;

  typedef struct packed {
    logic       setup;
    logic [2:0] addr;
    logic       rd;
  } setup_cmd_t;
endpackage

// File: rtl/tsr_spi_front.sv
module tsr_spi_front #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int SHIFT_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csn_i,
  input  logic               sclk_i,
  input  logic               din_i,
  output logic               active_o,
  output logic               rise_stb_o,
  output logic               fall_stb_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [SHIFT_W-1:0] shift_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] csn_sync, sclk_sync, din_sync;
  logic csn_s, sclk_s, din_s, sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_sync  <= '1;
      sclk_sync <= '0;
      din_sync  <= '0;
    end else begin
      csn_sync  <= {csn_sync[SYNC_STAGES-2:0], csn_i};
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      din_sync  <= {din_sync[SYNC_STAGES-2:0], din_i};
    end
  end

  assign csn_s  = csn_sync[SYNC_STAGES-1];
  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign din_s  = din_sync[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d     <= 1'b0;
      rise_stb_o <= 1'b0;
      fall_stb_o <= 1'b0;
      active_o   <= 1'b0;
      bit_cnt_o  <= '0;
      shift_o    <= '0;
    end else begin
      sclk_d     <= sclk_s;
      rise_stb_o <= 1'b0;
      fall_stb_o <= 1'b0;
      if (csn_s) begin
        active_o  <= 1'b0;
        bit_cnt_o <= '0;
        shift_o   <= '0;
      end else begin
        active_o <= 1'b1;
        if (sclk_s && !sclk_d) begin
          rise_stb_o <= 1'b1;
          if (bit_cnt_o != CNT_MAX) bit_cnt_o <= bit_cnt_o + 1'b1;
          shift_o <= {shift_o[SHIFT_W-2:0], din_s};
        end
        if (!sclk_s && sclk_d) fall_stb_o <= 1'b1;
      end
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_stb_o && fall_stb_o)); // R11
  AST_IDLE_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && csn_s) |=> (bit_cnt_o == '0)); // R11
endmodule

// File: rtl/tsr_cmd_dec.sv
module tsr_cmd_dec
  import touch_setup_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             rise_stb_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  input  logic [7:0]       shift_i,
  output logic             wr_en_o,
  output logic [2:0]       wr_addr_o,
  output logic [3:0]       wr_data_o,
  output logic             rd_frame_o,
  output logic [2:0]       rd_addr_o,
  output logic             arm_o,
  output logic             res_rd_o
);
  localparam logic [CNT_W-1:0] CNT_CMD = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_WR  = CNT_W'(WR_LAST);

  setup_cmd_t cmd_q, cmd_new;
  logic       cmd_vld_q;

  always_comb begin
    cmd_new.setup = (shift_i[7:4] == SETUP_PREFIX);
    cmd_new.addr  = shift_i[3:1];
    cmd_new.rd    = shift_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      cmd_vld_q <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      arm_o     <= 1'b0;
      res_rd_o  <= 1'b0;
    end else begin
      wr_en_o  <= 1'b0;
      arm_o    <= 1'b0;
      res_rd_o <= 1'b0;
      if (!active_i) begin
        cmd_vld_q <= 1'b0;
      end else if (rise_stb_i && bit_cnt_i == CNT_CMD) begin
        cmd_q     <= cmd_new;
        cmd_vld_q <= 1'b1;
        if (cmd_new.setup && cmd_new.addr == A_AUTO) begin
          arm_o    <= !cmd_new.rd;
          res_rd_o <= cmd_new.rd;
        end
      end else if (rise_stb_i && bit_cnt_i == CNT_WR && cmd_vld_q &&
                   cmd_q.setup && !cmd_q.rd && cmd_q.addr != A_AUTO) begin
        wr_en_o   <= 1'b1;
        wr_addr_o <= cmd_q.addr;
        wr_data_o <= shift_i[3:0];
      end
    end
  end

  assign rd_frame_o = cmd_vld_q && cmd_q.setup && cmd_q.rd && (cmd_q.addr != A_AUTO);
  assign rd_addr_o  = cmd_q.addr;

  AST_WR_AT_BIT12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (bit_cnt_i == CNT_WR)); // R4
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({arm_o, res_rd_o, wr_en_o})); // R10
  AST_ARM_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_o |=> !arm_o); // R10
  AST_RES_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_rd_o |=> !res_rd_o); // R10
endmodule

// File: rtl/tsr_regfile.sv
module tsr_regfile
  import touch_setup_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [3:0]  wr_data_i,
  input  logic [2:0]  rd_addr_i,
  input  logic [1:0]  status_i,
  output setup_regs_t regs_o,
  output logic [3:0]  rd_data_o
);
  setup_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_FUNC: {regs_q.panel_5w, regs_q.cont, regs_q.cnt10, regs_q.ddly} <= wr_data_i;
        A_SEQ:  regs_q.seq_mode <= wr_data_i[3:1];
        A_INTV: regs_q.interval <= wr_data_i[3:1];
        A_PWR:  if (wr_data_i[3:2] != SLEEP_RSVD) regs_q.sleep <= wr_data_i[3:2];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_FUNC:  rd_data_o = {regs_q.panel_5w, regs_q.cont, regs_q.cnt10, regs_q.ddly};
      A_SEQ:   rd_data_o = {regs_q.seq_mode, 1'b0};
      A_INTV:  rd_data_o = {regs_q.interval, 1'b0};
      A_PWR:   rd_data_o = {regs_q.sleep, status_i};
      default: rd_data_o = 4'b0000;
    endcase
  end

  assign regs_o = regs_q;

  AST_HOLD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q)); // R4
  AST_RSVD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[2]) |=> $stable(regs_q)); // R9
  AST_SLEEP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q.sleep != SLEEP_RSVD); // R8
endmodule

// File: rtl/tsr_dout.sv
module tsr_dout
  import touch_setup_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             fall_stb_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  input  logic             rd_frame_i,
  input  logic [3:0]       rd_data_i,
  output logic             dout_o,
  output logic             oe_o
);
  localparam logic [CNT_W-1:0] CNT_TURN = CNT_W'(RD_FIRST);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(RD_LAST);

  logic [3:0] shift_q;
  logic       oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      oe_q    <= 1'b0;
    end else if (!active_i) begin
      oe_q <= 1'b0;
    end else if (fall_stb_i && rd_frame_i) begin
      if (bit_cnt_i == CNT_TURN) begin
        shift_q <= rd_data_i;
        oe_q    <= 1'b1;
      end else if (bit_cnt_i > CNT_TURN && bit_cnt_i < CNT_END) begin
        shift_q <= {shift_q[2:0], 1'b0};
      end else if (bit_cnt_i >= CNT_END) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign oe_o   = oe_q;
  assign dout_o = oe_q & shift_q[3];

  AST_OE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !oe_q); // R11
  AST_OE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && active_i) |-> (bit_cnt_i >= CNT_TURN && bit_cnt_i <= CNT_END)); // R5
  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && active_i) |-> rd_frame_i); // R2
endmodule

// File: rtl/touch_setup_regs.sv
module touch_setup_regs
  import touch_setup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       csn_i,
  input  logic       sclk_i,
  input  logic       din_i,
  input  logic [1:0] seq_status_i,
  output logic       dout_o,
  output logic       dout_oe_o,
  output logic       panel_5w_o,
  output logic       cont_mode_o,
  output logic       conv_cnt_o,
  output logic       data_dly_o,
  output logic [2:0] seq_mode_o,
  output logic [2:0] interval_o,
  output logic [1:0] sleep_o,
  output logic       seq_arm_o,
  output logic       result_rd_o
);
  logic             active, rise_stb, fall_stb;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shift;
  logic             wr_en, rd_frame;
  logic [2:0]       wr_addr, rd_addr;
  logic [3:0]       wr_data, rd_data;
  setup_regs_t      regs;

  tsr_spi_front #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .SHIFT_W(CMD_BITS)) u_front (
    .clk_i, .rst_ni, .csn_i, .sclk_i, .din_i,
    .active_o(active), .rise_stb_o(rise_stb), .fall_stb_o(fall_stb),
    .bit_cnt_o(bit_cnt), .shift_o(shift)
  );

  tsr_cmd_dec #(.CNT_W(CNT_W)) u_dec (
    .clk_i, .rst_ni,
    .active_i(active), .rise_stb_i(rise_stb), .bit_cnt_i(bit_cnt), .shift_i(shift),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_frame_o(rd_frame), .rd_addr_o(rd_addr),
    .arm_o(seq_arm_o), .res_rd_o(result_rd_o)
  );

  tsr_regfile u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .status_i(seq_status_i),
    .regs_o(regs), .rd_data_o(rd_data)
  );

  tsr_dout #(.CNT_W(CNT_W)) u_dout (
    .clk_i, .rst_ni,
    .active_i(active), .fall_stb_i(fall_stb), .bit_cnt_i(bit_cnt),
    .rd_frame_i(rd_frame), .rd_data_i(rd_data),
    .dout_o(dout_o), .oe_o(dout_oe_o)
  );

  assign panel_5w_o  = regs.panel_5w;
  assign cont_mode_o = regs.cont;
  assign conv_cnt_o  = regs.cnt10;
  assign data_dly_o  = regs.ddly;
  assign seq_mode_o  = regs.seq_mode;
  assign interval_o  = regs.interval;
  assign sleep_o     = regs.sleep;

  AST_AUTO_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_arm_o || result_rd_o) |-> !dout_oe_o); // R10
endmodule

// File: tb/touch_setup_regs_tb.sv
module touch_setup_regs_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [1:0] status = 2'b00;
  logic dout, dout_oe, panel, cont, cnt10, ddly, arm, resrd;
  logic [2:0] seqm, intv;
  logic [1:0] sleep;

  int n_chk = 0, n_bad = 0;
  int arm_cnt = 0, res_cnt = 0;
  bit done = 0;

  // model state
  logic [3:0] m_func;
  logic [2:0] m_seq, m_intv;
  logic [1:0] m_sleep;

  always #5 clk = ~clk;

  touch_setup_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .csn_i(csn), .sclk_i(sclk), .din_i(din),
    .seq_status_i(status), .dout_o(dout), .dout_oe_o(dout_oe),
    .panel_5w_o(panel), .cont_mode_o(cont), .conv_cnt_o(cnt10), .data_dly_o(ddly),
    .seq_mode_o(seqm), .interval_o(intv), .sleep_o(sleep),
    .seq_arm_o(arm), .result_rd_o(resrd)
  );

  always @(posedge clk) begin
    if (arm) arm_cnt <= arm_cnt + 1;
    if (resrd) res_cnt <= res_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] model_regs();
    return {m_func, m_seq, m_intv, m_sleep};
  endfunction

  function automatic logic [3:0] model_read(input logic [2:0] a, input logic [1:0] st);
    case (a)
      3'd0: return m_func;
      3'd1: return {m_seq, 1'b0};
      3'd2: return {m_intv, 1'b0};
      3'd3: return {m_sleep, st};
      default: return 4'b0000;
    endcase
  endfunction

  function automatic void model_write(input logic [2:0] a, input logic [3:0] d);
    case (a)
      3'd0: m_func = d;
      3'd1: m_seq = d[3:1];
      3'd2: m_intv = d[3:1];
      3'd3: if (d[3:2] != 2'b11) m_sleep = d[3:2];
      default: ;
    endcase
  endfunction

  task automatic run_frame(input logic [7:0] cmd, input logic [3:0] data, input int nclk,
                           output logic [15:0] oe_vec, output logic [3:0] rd_nib,
                           output logic oe_after);
    oe_vec = '0;
    rd_nib = '0;
    @(negedge clk) csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 1; k <= nclk; k++) begin
      if (k <= 8) din = cmd[8-k];
      else if (k <= 12) din = data[12-k];
      else din = 1'b0;
      repeat (H) @(negedge clk);
      oe_vec[k] = dout_oe;
      if (k >= 10 && k <= 13) rd_nib[13-k] = dout;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    oe_vec[0] = dout_oe;
    csn = 1'b1;
    din = 1'b0;
    repeat (8) @(negedge clk);
    oe_after = dout_oe;
  endtask

  // full frame with model bookkeeping and checks
  task automatic do_frame(input logic [7:0] cmd, input logic [3:0] data, input int nclk,
                          input string tag);
    logic [15:0] oe_vec, oe_exp;
    logic [3:0]  nib, nib_exp, mask;
    logic        oe_after, setup, rdf;
    int          arm0, res0, arm_exp, res_exp;
    setup   = (cmd[7:4] == 4'b1010);
    rdf     = setup && cmd[0] && (cmd[3:1] != 3'd7);
    nib_exp = model_read(cmd[3:1], status);
    oe_exp  = '0;
    mask    = '0;
    for (int k = 10; k <= 13; k++)
      if (k <= nclk && rdf) begin oe_exp[k] = 1'b1; mask[13-k] = 1'b1; end
    oe_exp[0] = rdf && nclk >= 9 && nclk <= 12;
    arm0 = arm_cnt; res0 = res_cnt;
    arm_exp = arm0 + ((setup && cmd[3:1] == 3'd7 && !cmd[0] && nclk >= 8) ? 1 : 0);
    res_exp = res0 + ((setup && cmd[3:1] == 3'd7 && cmd[0] && nclk >= 8) ? 1 : 0);
    run_frame(cmd, data, nclk, oe_vec, nib, oe_after);
    if (setup && !cmd[0] && nclk >= 12) model_write(cmd[3:1], data);
    check({tag, " R3/R4 regs"}, 32'({panel, cont, cnt10, ddly, seqm, intv, sleep}), 32'(model_regs()));
    check({tag, " R5 oe window"}, 32'(oe_vec), 32'(oe_exp));
    check({tag, " R6 read data"}, 32'(nib & mask), 32'(nib_exp & mask));
    check({tag, " R11 oe after csn"}, 32'(oe_after), 32'd0);
    check({tag, " R10 arm pulses"}, 32'(arm_cnt), 32'(arm_exp));
    check({tag, " R10 result pulses"}, 32'(res_cnt), 32'(res_exp));
  endtask

  function automatic logic [7:0] scmd(input logic [2:0] a, input logic rd);
    return {4'b1010, a, rd};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4185));
    m_func = '0; m_seq = '0; m_intv = '0; m_sleep = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 regs", 32'({panel, cont, cnt10, ddly, seqm, intv, sleep}), 32'd0);
    check("R1 oe", 32'({dout_oe, dout}), 32'd0);
    check("R1 pulses", 32'(arm_cnt + res_cnt), 32'd0);

    // R3 writes, R6 reads
    do_frame(scmd(3'd0, 1'b0), 4'b1011, 12, "R3 func write");
    check("R3 panel_5w", 32'(panel), 32'd1);
    do_frame(scmd(3'd0, 1'b1), 4'b0000, 13, "R6 func read");
    do_frame(scmd(3'd1, 1'b0), 4'b1011, 13, "R3 seq write");
    check("R3 seq_mode", 32'(seqm), 32'd5);
    do_frame(scmd(3'd1, 1'b1), 4'b1111, 13, "R6 seq read");
    do_frame(scmd(3'd2, 1'b0), 4'b0111, 12, "R3 intv write");
    do_frame(scmd(3'd2, 1'b1), 4'b0000, 13, "R6 intv read");
    // R7 status read-only
    status = 2'b01;
    do_frame(scmd(3'd3, 1'b0), 4'b1010, 12, "R7 pwr write");
    do_frame(scmd(3'd3, 1'b1), 4'b0000, 13, "R7 pwr read");
    check("R7 sleep", 32'(sleep), 32'd2);
    // R8 reserved sleep code
    do_frame(scmd(3'd3, 1'b0), 4'b1100, 12, "R8 sleep rsvd");
    check("R8 sleep kept", 32'(sleep), 32'd2);
    // R4 truncated write
    do_frame(scmd(3'd0, 1'b0), 4'b0100, 11, "R4 truncated");
    check("R4 func kept", 32'({panel, cont, cnt10, ddly}), 32'hB);
    // R9 reserved addresses
    do_frame(scmd(3'd5, 1'b0), 4'b1111, 13, "R9 rsvd write");
    do_frame(scmd(3'd5, 1'b1), 4'b1111, 13, "R9 rsvd read");
    // R2 foreign command bytes
    do_frame(8'b1001_0110, 4'b1111, 13, "R2 foreign");
    do_frame(8'b0010_0000, 4'b0000, 13, "R2 no start");
    // R10 sequence commands
    do_frame(scmd(3'd7, 1'b0), 4'b1111, 12, "R10 arm");
    do_frame(scmd(3'd7, 1'b1), 4'b0000, 13, "R10 result");
    // R11 aborted read then fresh frame
    do_frame(scmd(3'd0, 1'b1), 4'b0000, 11, "R11 cut read");
    do_frame(scmd(3'd0, 1'b1), 4'b0000, 13, "R11 fresh read");

    for (int i = 0; i < 60; i++) begin
      logic [7:0] cmd;
      logic [3:0] dat;
      int nc;
      if (($urandom % 8) != 0) cmd = scmd(3'($urandom % 8), 1'($urandom % 2));
      else begin
        cmd = 8'($urandom);
        if (cmd[7:4] == 4'b1010) cmd[6] = 1'b1;
      end
      dat = 4'($urandom);
      nc = (($urandom % 4) == 0) ? 8 + int'($urandom % 5) : 13;
      status = 2'($urandom);
      do_frame(cmd, dat, nc, "rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule